// File: doc/BRIEF.md
# Banked Cache Portion Permission Table

This block stores, for every partition identifier, a bitmap that says which cache portions the partition may allocate into. A set bit grants allocation into the portion with that index, and a clear bit denies it. Software reaches the bitmaps indirectly. It first writes a partition-select register at offset 0x0000 of a frame. It then reads or writes the selected partition's bitmap through a window of 32-bit words that starts at offset 0x1000.

There are two independent banks, each with its own select register and its own bitmap storage. The secure bank is reached only through requests with the secure frame bit set, and the non-secure bank only through requests with that bit clear. A separate lookup port lets the cache's allocation logic ask, once per cycle, whether a given partition of a given security state may allocate into a given portion.

The number of partitions, the number of implemented portion bits (1 to 32768) and whether the portion-partitioning capability is present are all parameters.

Top module: `cpt_perm_table`

## Requirements
- R1: Reset makes every implemented bitmap bit 1 in both banks, so every in-range partition is permitted into every implemented portion, and reset makes both select registers 0.
- R2: A window word at offset 0x1000 + 4*k holds bitmap bits 32k (word bit 0) to 32k+31 (word bit 31) of the selected partition. Writing it replaces those bits, and reading it returns them.
- R3: Bitmap bits at or above PORT_BITS are not stored. In the last partial word they read as 0, and writes to them are ignored.
- R4: Window words with index k at or above ceil(PORT_BITS/32), up to the window end at 0x1FFC, read as 0 and ignore writes.
- R5: A write to offset 0x0000 sets the select register of the bank chosen by req_secure to req_wdata[PART_W-1:0]. A read of offset 0x0000 returns that value zero-extended. Window accesses act on the partition that this register names.
- R6: A request with req_secure=1 reads and writes only the secure bank, and a request with req_secure=0 only the non-secure bank. Neither kind of request ever alters the other bank's bitmaps or select register.
- R7: When a bank's select value is at or above NUM_PARTS, window reads in that bank return 0 and window writes change no bitmap.
- R8: With HAS_PORTIONS=0, window reads return 0 and window writes have no effect, so the lookup keeps reporting the reset permissions. The select register still works.
- R9: The lookup answer on lk_allow is the bitmap bit for (lk_secure, lk_part, lk_portion) and is registered one cycle after the inputs. It is 0 when lk_portion >= PORT_BITS or lk_part >= NUM_PARTS.
- R10: Each read request produces rsp_valid=1 with rsp_rdata on the following cycle, and a write produces no response. Offsets that are neither the select register nor the window read as 0 and ignore writes. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Frame select: 1 = secure bank, 0 = non-secure bank |
| req_addr | input | ADDR_W | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 32 | Read data |
| lk_secure | input | 1 | Lookup security state |
| lk_part | input | PART_W | Lookup partition identifier |
| lk_portion | input | 15 | Lookup cache portion index |
| lk_allow | output | 1 | Registered permission result |

## Verification
The bench builds the table with three partitions and 40 portion bits. This gives one full word, one partial word with eight live bits and a row of unimplemented words in the window. It also puts a select value just past the partition count within reach. A second copy, built with the capability absent, shares every input, so each window access is also checked against the reserved behaviour. With a configuration this small, the bench can sweep every partition, every window word and every portion index, plus a margin beyond each limit, in both banks, both after reset and after distinct per-bank patterns have been written.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned SEL_OFFSET   = 32'h0000_0000;
    localparam int unsigned WIN_OFFSET   = 32'h0000_1000;
    localparam int unsigned WIN_WORDS    = 1024;
    localparam int unsigned WIN_IDX_W    = 10;
    localparam int unsigned PORTION_IDX_W = 15;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_SEL   = 2'd1,
        ACC_WIN   = 2'd2,
        ACC_OTHER = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic                   valid;
        logic                   write;
        logic                   secure;
        acc_kind_e              kind;
        logic [WIN_IDX_W-1:0]   word;
        logic [WORD_W-1:0]      wdata;
    } bus_req_t;

    function automatic int unsigned words_for(input int unsigned bits);
        return (bits + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Live bits of word k for a bitmap that is 'bits' wide.
    function automatic logic [WORD_W-1:0] word_mask(input int unsigned k,
                                                    input int unsigned bits);
        int unsigned lo;
        lo = k * WORD_W;
        if (lo >= bits)               return '0;
        if (bits - lo >= WORD_W)      return '1;
        return (WORD_W'(1) << (bits - lo)) - WORD_W'(1);
    endfunction

endpackage

// File: rtl/cpt_decode.sv
module cpt_decode
    import cpt_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              valid,
    input  logic              write,
    input  logic              secure,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output bus_req_t          req
);

    logic [31:0] aligned;
    logic [31:0] win_rel;

    always_comb begin
        aligned = 32'(addr) & ~32'h3;
        win_rel = aligned - WIN_OFFSET;
        req.valid  = valid;
        req.write  = write;
        req.secure = secure;
        req.wdata  = wdata;
        req.word   = win_rel[WIN_IDX_W+1:2];
        if (!valid)
            req.kind = ACC_NONE;
        else if (aligned == SEL_OFFSET)
            req.kind = ACC_SEL;
        else if (aligned >= WIN_OFFSET && aligned < WIN_OFFSET + 4 * WIN_WORDS)
            req.kind = ACC_WIN;
        else
            req.kind = ACC_OTHER;
    end

endmodule

// File: rtl/cpt_bank.sv
module cpt_bank
    import cpt_pkg::*;
#(
    parameter int unsigned NUM_PARTS    = 8,
    parameter int unsigned PORT_BITS    = 80,
    parameter int unsigned PART_W       = 8,
    parameter bit          HAS_PORTIONS = 1'b1,
    parameter bit          BANK_SEC     = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  bus_req_t                 req,
    input  logic [PART_W-1:0]        lk_part,
    input  logic [PORTION_IDX_W-1:0] lk_portion,
    output logic [WORD_W-1:0]        rd_word,
    output logic                     lk_bit
);

    localparam int unsigned WORDS  = words_for(PORT_BITS);
    localparam int unsigned PIDX_W = idx_w(NUM_PARTS);
    localparam int unsigned WIDX_W = idx_w(WORDS);

    logic [WORD_W-1:0] mem [NUM_PARTS][WORDS];
    logic [PART_W-1:0] sel_q;

    logic              hit;
    logic              sel_ok;
    logic              word_ok;
    logic [PIDX_W-1:0] sel_idx;
    logic [WIDX_W-1:0] w_idx;
    logic [WORD_W-1:0] w_mask;

    always_comb begin
        hit     = req.valid && (req.secure == BANK_SEC);
        sel_ok  = 32'(sel_q) < NUM_PARTS;
        word_ok = 32'(req.word) < WORDS;
        sel_idx = sel_q[PIDX_W-1:0];
        w_idx   = req.word[WIDX_W-1:0];
        w_mask  = word_mask(int'(req.word), PORT_BITS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            for (int p = 0; p < NUM_PARTS; p++)
                for (int w = 0; w < WORDS; w++)
                    mem[p][w] <= word_mask(w, PORT_BITS);
        end else if (hit && req.write) begin
            if (req.kind == ACC_SEL)
                sel_q <= req.wdata[PART_W-1:0];
            if (req.kind == ACC_WIN && HAS_PORTIONS && sel_ok && word_ok)
                mem[sel_idx][w_idx] <= req.wdata & w_mask;
        end
    end

    always_comb begin
        rd_word = '0;
        case (req.kind)
            ACC_SEL: rd_word = WORD_W'(sel_q);
            ACC_WIN: if (HAS_PORTIONS && sel_ok && word_ok)
                         rd_word = mem[sel_idx][w_idx];
            default: rd_word = '0;
        endcase
    end

    logic              lk_ok;
    logic [PIDX_W-1:0] lk_pidx;
    logic [WIDX_W-1:0] lk_widx;

    always_comb begin
        lk_ok   = (32'(lk_part) < NUM_PARTS) && (32'(lk_portion) < PORT_BITS);
        lk_pidx = lk_part[PIDX_W-1:0];
        lk_widx = lk_portion[WIDX_W+4:5];
        lk_bit  = lk_ok ? mem[lk_pidx][lk_widx][lk_portion[4:0]] : 1'b0;
    end

endmodule

// File: rtl/cpt_perm_table.sv
module cpt_perm_table
    import cpt_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned PART_W       = 8,
    parameter int unsigned NUM_PARTS    = 8,
    parameter int unsigned PORT_BITS    = 80,
    parameter bit          HAS_PORTIONS = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic                     req_secure,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    input  logic                     lk_secure,
    input  logic [PART_W-1:0]        lk_part,
    input  logic [PORTION_IDX_W-1:0] lk_portion,
    output logic                     lk_allow
);

    bus_req_t          req;
    logic [WORD_W-1:0] bank_rd [2];
    logic              bank_lk [2];

    cpt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .valid  (req_valid),
        .write  (req_write),
        .secure (req_secure),
        .addr   (req_addr),
        .wdata  (req_wdata),
        .req    (req)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        cpt_bank #(
            .NUM_PARTS    (NUM_PARTS),
            .PORT_BITS    (PORT_BITS),
            .PART_W       (PART_W),
            .HAS_PORTIONS (HAS_PORTIONS),
            .BANK_SEC     (b[0])
        ) u_bank (
            .clk        (clk),
            .rst        (rst),
            .req        (req),
            .lk_part    (lk_part),
            .lk_portion (lk_portion),
            .rd_word    (bank_rd[b]),
            .lk_bit     (bank_lk[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            lk_allow  <= 1'b0;
        end else begin
            rsp_valid <= req.valid && !req.write;
            rsp_rdata <= (req.valid && !req.write)
                         ? bank_rd[req.secure ? 1 : 0] : '0;
            lk_allow  <= bank_lk[lk_secure ? 1 : 0];
        end
    end

endmodule

// File: rtl/cpt_perm_table_chk.sv
module cpt_perm_table_chk
    import cpt_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned PART_W       = 8,
    parameter int unsigned NUM_PARTS    = 8,
    parameter int unsigned PORT_BITS    = 80,
    parameter bit          HAS_PORTIONS = 1'b1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_valid,
    input logic                     req_write,
    input logic [ADDR_W-1:0]        req_addr,
    input logic                     rsp_valid,
    input logic [31:0]              rsp_rdata,
    input logic [PART_W-1:0]        lk_part,
    input logic [PORTION_IDX_W-1:0] lk_portion,
    input logic                     lk_allow
);

    localparam int unsigned WORDS     = words_for(PORT_BITS);
    localparam logic [31:0] LAST_MASK = word_mask(WORDS - 1, PORT_BITS);
    localparam logic [31:0] LAST_ADDR = WIN_OFFSET + 4 * (WORDS - 1);

    logic        rd_req;
    logic [31:0] a32;
    logic        in_win;
    logic [31:0] widx;

    always_comb begin
        rd_req = req_valid && !req_write;
        a32    = 32'(req_addr) & ~32'h3;
        in_win = a32 >= WIN_OFFSET && a32 < WIN_OFFSET + 4 * WIN_WORDS;
        widx   = (a32 - WIN_OFFSET) >> 2;
    end

    // R10
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid);

    // R10
    no_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_valid);

    // R3
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && a32 == LAST_ADDR) |=> ((rsp_rdata & ~LAST_MASK) == 32'd0));

    // R4
    beyond_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && in_win && widx >= WORDS) |=> (rsp_rdata == 32'd0));

    // R9
    lk_portion_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(lk_portion) >= PORT_BITS) |=> !lk_allow);

    // R9
    lk_part_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(lk_part) >= NUM_PARTS) |=> !lk_allow);

    if (!HAS_PORTIONS) begin : g_absent
        // R8
        absent_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_req && in_win) |=> (rsp_rdata == 32'd0));
    end

endmodule

bind cpt_perm_table cpt_perm_table_chk #(
    .ADDR_W       (ADDR_W),
    .PART_W       (PART_W),
    .NUM_PARTS    (NUM_PARTS),
    .PORT_BITS    (PORT_BITS),
    .HAS_PORTIONS (HAS_PORTIONS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .lk_part    (lk_part),
    .lk_portion (lk_portion),
    .lk_allow   (lk_allow)
);

// File: tb/cpt_perm_table_tb.sv
`timescale 1ns/1ps
module cpt_perm_table_tb;

    localparam int NP = 3;
    localparam int PB = 40;
    localparam int PW = 8;
    localparam int AW = 16;
    localparam int NW = (PB + 31) / 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          lk_secure = 1'b0;
    logic [PW-1:0] lk_part = '0;
    logic [14:0]   lk_portion = '0;
    logic          rsp_valid, lk_allow, nc_rsp_valid, nc_lk_allow;
    logic [31:0]   rsp_rdata, nc_rsp_rdata;

    cpt_perm_table #(.ADDR_W(AW), .PART_W(PW), .NUM_PARTS(NP),
                     .PORT_BITS(PB), .HAS_PORTIONS(1'b1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lk_secure(lk_secure),
        .lk_part(lk_part), .lk_portion(lk_portion), .lk_allow(lk_allow));

    cpt_perm_table #(.ADDR_W(AW), .PART_W(PW), .NUM_PARTS(NP),
                     .PORT_BITS(PB), .HAS_PORTIONS(1'b0)) u_dut_nocap (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(nc_rsp_valid), .rsp_rdata(nc_rsp_rdata), .lk_secure(lk_secure),
        .lk_part(lk_part), .lk_portion(lk_portion), .lk_allow(nc_lk_allow));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] mdl [2][NP][NW];

    function automatic logic [31:0] emask(int k);
        int lo = k * 32;
        if (lo >= PB) return 32'd0;
        if (PB - lo >= 32) return 32'hFFFF_FFFF;
        return (32'd1 << (PB - lo)) - 32'd1;
    endfunction

    function automatic bit exp_bit(int sec, int part, int portion);
        if (part >= NP || portion >= PB) return 1'b0;
        return mdl[sec][part][portion / 32][portion % 32];
    endfunction

    task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(bit sec, int addr, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_secure = sec;
        req_addr = addr[AW-1:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(rsp_valid == 1'b0, "R10 write no response", 32'(rsp_valid), 32'd0);
    endtask

    task automatic rd(bit sec, int addr, logic [31:0] exp, logic [31:0] nexp, string rq);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_secure = sec;
        req_addr = addr[AW-1:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R10 read response", 32'(rsp_valid), 32'd1);
        chk(rsp_rdata == exp, rq, rsp_rdata, exp);
        chk(nc_rsp_rdata == nexp, "R8 absent capability read", nc_rsp_rdata, nexp);
    endtask

    task automatic lk(bit sec, int part, int portion, string rq);
        bit e, ne;
        @(negedge clk);
        lk_secure = sec; lk_part = part[PW-1:0]; lk_portion = portion[14:0];
        @(negedge clk);
        e  = exp_bit(sec, part, portion);
        ne = (part < NP && portion < PB);
        chk(lk_allow == e, rq, 32'(lk_allow), 32'(e));
        chk(nc_lk_allow == ne, "R8 absent capability lookup", 32'(nc_lk_allow), 32'(ne));
    endtask

    task automatic sweep_read(string rq);
        for (int b = 0; b < 2; b++)
            for (int p = 0; p < NP; p++) begin
                wr(b[0], 0, p);
                for (int k = 0; k < NW + 2; k++) begin
                    logic [31:0] e;
                    e = 32'd0;
                    if (k < NW) e = mdl[b][p][k];
                    rd(b[0], 32'h1000 + 4 * k, e, 32'd0, rq);
                end
            end
    endtask

    task automatic sweep_lookup(string rq);
        for (int b = 0; b < 2; b++)
            for (int p = 0; p <= NP; p++)
                for (int n = 0; n < PB + 8; n++)
                    lk(b[0], p, n, rq);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        report();
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int p = 0; p < NP; p++)
                for (int k = 0; k < NW; k++)
                    mdl[b][p][k] = emask(k);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: select registers reset to 0 in both banks
        rd(1'b1, 0, 32'd0, 32'd0, "R1 secure select reset");
        rd(1'b0, 0, 32'd0, 32'd0, "R1 non-secure select reset");
        // R1, R3, R4: reset contents of the window
        sweep_read("R1 reset bitmap word");
        // R1, R9: reset lookups, including out-of-range cases
        sweep_lookup("R9 lookup after reset");

        // R2, R3, R4, R5: distinct pattern per bank, partition and word
        for (int b = 0; b < 2; b++)
            for (int p = 0; p < NP; p++) begin
                wr(b[0], 0, p);
                for (int k = 0; k < NW + 2; k++) begin
                    logic [31:0] pat;
                    pat = 32'h9E37_79B9 * (b * 16 + p * 4 + k + 1);
                    wr(b[0], 32'h1000 + 4 * k + (k % 4), pat);
                    if (k < NW) mdl[b][p][k] = pat & emask(k);
                end
            end
        // R5: select read-back after the sweep
        rd(1'b1, 0, NP - 1, NP - 1, "R5 select read-back");
        // R2, R3, R4, R6: both banks keep their own patterns
        sweep_read("R6 bank isolation readback");
        sweep_lookup("R2 lookup after writes");

        // R6: a secure write leaves the non-secure bank untouched
        wr(1'b1, 0, 1);
        wr(1'b1, 32'h1000, 32'h0);
        mdl[1][1][0] = 32'h0;
        wr(1'b0, 0, 1);
        rd(1'b0, 32'h1000, mdl[0][1][0], 32'd0, "R6 non-secure untouched");
        rd(1'b1, 0, 32'd1, 32'd1, "R6 secure select kept");

        // R7: select value just beyond the partition count
        wr(1'b0, 0, NP);
        rd(1'b0, 0, NP, NP, "R5 out-of-range select stored");
        wr(1'b0, 32'h1000, 32'hDEAD_BEEF);
        rd(1'b0, 32'h1000, 32'd0, 32'd0, "R7 out-of-range select reads zero");
        wr(1'b0, 0, 200);
        wr(1'b0, 32'h1004, 32'hFFFF_FFFF);
        rd(1'b0, 32'h1004, 32'd0, 32'd0, "R7 far select reads zero");

        // R10: other offsets read zero and ignore writes
        wr(1'b1, 32'h0800, 32'h1234_5678);
        rd(1'b1, 32'h0800, 32'd0, 32'd0, "R10 other offset");
        wr(1'b0, 32'h2000, 32'hFFFF_FFFF);
        rd(1'b0, 32'h2000, 32'd0, 32'd0, "R10 past window end");
        // R4: last word of the window
        wr(1'b0, 0, 0);
        rd(1'b0, 32'h1FFC, 32'd0, 32'd0, "R4 final window word");

        // R7, R10, R8: nothing changed by the ignored writes
        sweep_read("R7 contents unchanged");
        sweep_lookup("R9 lookup final");

        report();
    end

endmodule